// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous memory whose reads flow straight from the array to the data outputs in the same cycle that the read command is registered. Its write data arrives one enabled clock edge after the write command. The two directions can therefore alternate on every cycle with no idle slot between them. Every command input is sampled on the rising edge of `clk_i`, and only when the active-low clock enable is low. When the clock enable is high, the edge is a stall and all internal state holds.

A command is either a new operation or a continue. A new operation loads the address, the two low address bits of which seed a 2-bit beat counter. A continue advances the current burst, or keeps a deselected core deselected. Each burst is either linear (wrapping increment) or interleaved (start XOR beat count), chosen at load time. A captured write is held in a posted-write register and is retired into the array by the next write. Any read whose address matches a held write sees the held write's data, merged per lane. The data bus is a split pair of ports with an output-enable signal that drives an external tristate buffer. A sleep input parks the core after a fixed number of clocks and wakes it after the same number, with the contents kept.

Top module: `ftsram_core`

## Requirements
- R1: After reset, `dq_oe_o` is low and no operation is in flight.
- R2: An edge with `clk_en_ni` high is ignored. A read output keeps showing the same word, and a pending write's data is captured at the next enabled edge instead.
- R3: A new command (`adv_i` low) with `sel_a_ni` high, `sel_b_i` low or `sel_c_ni` high deselects the core, and `dq_oe_o` is low in the following cycle. A later continue (`adv_i` high) keeps it deselected.
- R4: A read (all enables active, `adv_i` low, `wr_ni` high) places the addressed word on `dq_o` in the cycle right after that edge. `dq_oe_o` is high in that cycle only while `out_en_ni` is low.
- R5: A write (`wr_ni` low) captures `dq_i` at the next enabled edge. Lane i is bits [9i+8:9i] and is written only when `byte_wr_ni[i]` is 0; all other lanes keep their contents.
- R6: In a linear burst, beat k uses low address bits (start + k) mod 4, and the upper address bits stay fixed.
- R7: When `interleave_i` is high at load, beat k uses low address bits start XOR k.
- R8: Each continue beat of a write burst uses the `byte_wr_ni` value sampled on that beat's own edge.
- R9: A read issued on the edge that captures a write's data, or on any later edge, returns the newest data merged per lane. Reads and writes alternate on consecutive edges with no idle cycle.
- R10: Once `sleep_i` has been high for SLEEP_LAT edges, commands are ignored and `dq_oe_o` stays low. The array contents are kept.
- R11: Once `sleep_i` has been low for SLEEP_LAT edges, commands are accepted again. Commands on those SLEEP_LAT edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high stalls the core |
| sel_a_ni | input | 1 | Chip enable A, active low |
| sel_b_i | input | 1 | Chip enable B, active high |
| sel_c_ni | input | 1 | Chip enable C, active low |
| adv_i | input | 1 | Low: load a new command; high: continue the current one |
| wr_ni | input | 1 | Write enable, active low |
| byte_wr_ni | input | LANES | Lane write strobes, active low |
| out_en_ni | input | 1 | Output enable, active low, asynchronous |
| interleave_i | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| sleep_i | input | 1 | Low-power request |
| addr_i | input | AW | Word address |
| dq_i | input | LANES*LANE_W | Write data bus |
| dq_o | output | LANES*LANE_W | Read data bus |
| dq_oe_o | output | 1 | Drive enable for the read data bus |

## Verification
The assertions assume two things about the inputs. First, command inputs settle between edges. Second, write data is held on `dq_i` from the write's edge until the next enabled edge, including across any stall cycles. The bench's driver applies inputs shortly after the falling edge and leaves the bus value untouched on stall steps, so both assumptions always hold. Sleep is only entered from a deselected state with no write pending, since accesses in flight at entry are not guaranteed. The stimulus therefore issues deselects before and throughout the entry window.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/ftsram_burst.sv
module ftsram_burst
  import ftsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          interleave_i,
  input  logic [AW-1:0] start_addr_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          ilv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= start_addr_i;
      cnt_q  <= '0;
      ilv_q  <= interleave_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign addr_o = {base_q[AW-1:2], beat_lsb(base_q[1:0], cnt_q, ilv_q)};

  assert_load_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_addr_i));

  assert_upper_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> addr_o[AW-1:2] == $past(addr_o[AW-1:2]));

  assert_ilv_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && ilv_q) |=> (addr_o[1:0] ^ $past(addr_o[1:0])) == (cnt_q ^ $past(cnt_q)));

endmodule

// File: rtl/ftsram_wbuf.sv
module ftsram_wbuf #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [AW-1:0]    cap_addr_i,
  input  logic [LANES-1:0] cap_be_i,
  input  logic [W-1:0]     cap_data_i,
  output logic             commit_o,
  output logic [AW-1:0]    commit_addr_o,
  output logic [LANES-1:0] commit_be_o,
  output logic [W-1:0]     commit_data_o,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [W-1:0]     rd_mem_i,
  output logic [W-1:0]     rd_data_o
);

  logic             valid_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] be_q;
  logic [W-1:0]     data_q;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      data_q  <= '0;
    end else if (cap_i) begin
      valid_q <= 1'b1;
      addr_q  <= cap_addr_i;
      be_q    <= cap_be_i;
      data_q  <= cap_data_i;
    end
  end

  // older posted write retires when a newer one is captured
  assign commit_o      = cap_i & valid_q;
  assign commit_addr_o = addr_q;
  assign commit_be_o   = be_q;
  assign commit_data_o = data_q;

  assign hit = valid_q && (addr_q == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign rd_data_o[g*LANE_W +: LANE_W] = (hit && be_q[g]) ? data_q[g*LANE_W +: LANE_W]
                                                             : rd_mem_i[g*LANE_W +: LANE_W];
  end

  assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (valid_q && addr_q == $past(cap_addr_i) && data_q == $past(cap_data_i)));

  assert_forward_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && cap_be_i == '1) |=> (rd_addr_i != addr_q || rd_data_o == data_q));

endmodule

// File: rtl/ftsram_sleep.sv
module ftsram_sleep #(
  parameter int LAT = 2,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic asleep_o
);

  logic [CW-1:0] ctr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q    <= '0;
      asleep_o <= 1'b0;
    end else if (sleep_i != asleep_o) begin
      if (ctr_q == CW'(LAT - 1)) begin
        ctr_q    <= '0;
        asleep_o <= sleep_i;
      end else begin
        ctr_q    <= ctr_q + 1'b1;
      end
    end else begin
      ctr_q <= '0;
    end
  end

  assert_enter_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> $past(sleep_i));

  assert_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> !$past(sleep_i));

endmodule

// File: rtl/ftsram_core.sv
module ftsram_core
  import ftsram_pkg::*;
#(
  parameter int AW        = 6,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int SLEEP_LAT = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_ni,
  input  logic                    sel_a_ni,
  input  logic                    sel_b_i,
  input  logic                    sel_c_ni,
  input  logic                    adv_i,
  input  logic                    wr_ni,
  input  logic [LANES-1:0]        byte_wr_ni,
  input  logic                    out_en_ni,
  input  logic                    interleave_i,
  input  logic                    sleep_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);

  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  op_e              op_q;
  logic [LANES-1:0] be_q;
  logic             asleep_q;
  logic [AW-1:0]    cur_addr;
  logic             en, desel, load, step, cap;
  logic             commit;
  logic [AW-1:0]    commit_addr;
  logic [LANES-1:0] commit_be;
  logic [W-1:0]     commit_data;
  logic [W-1:0]     rd_mem;
  logic [W-1:0]     mem_q [DEPTH];

  assign en    = ~clk_en_ni & ~asleep_q;
  assign desel = sel_a_ni | ~sel_b_i | sel_c_ni;
  assign load  = en & ~adv_i;
  assign step  = en & adv_i & (op_q != OP_IDLE);
  assign cap   = en & (op_q == OP_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       op_q <= OP_IDLE;
    else if (asleep_q) op_q <= OP_IDLE;
    else if (load)     op_q <= desel ? OP_IDLE : (wr_ni ? OP_READ : OP_WRITE);
  end

  // strobes follow every beat, not only the first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           be_q <= '0;
    else if (load || step) be_q <= ~byte_wr_ni;
  end

  ftsram_sleep #(.LAT(SLEEP_LAT)) u_sleep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .asleep_o (asleep_q)
  );

  ftsram_burst #(.AW(AW)) u_burst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .step_i       (step),
    .interleave_i (interleave_i),
    .start_addr_i (addr_i),
    .addr_o       (cur_addr)
  );

  ftsram_wbuf #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cap_i         (cap),
    .cap_addr_i    (cur_addr),
    .cap_be_i      (be_q),
    .cap_data_i    (dq_i),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_be_o   (commit_be),
    .commit_data_o (commit_data),
    .rd_addr_i     (cur_addr),
    .rd_mem_i      (rd_mem),
    .rd_data_o     (dq_o)
  );

  always_ff @(posedge clk_i) begin
    if (commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (commit_be[l]) mem_q[commit_addr][l*LANE_W +: LANE_W] <= commit_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_mem  = mem_q[cur_addr];
  assign dq_oe_o = (op_q == OP_READ) & ~out_en_ni & ~asleep_q;

  assert_stall_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_ni && !asleep_q) |=> ($stable(op_q) && $stable(cur_addr) && $stable(be_q)));

  assert_deselect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !adv_i && desel) |=> !dq_oe_o);

  assert_desel_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && adv_i && op_q == OP_IDLE) |=> op_q == OP_IDLE);

  assert_oe_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> !dq_oe_o);

  assert_sleep_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(asleep_q) && asleep_q |-> (op_q == OP_IDLE && !dq_oe_o));

endmodule

// File: tb/ftsram_core_test.sv
module ftsram_core_test;

  typedef struct {
    bit          exp_oe;
    logic [35:0] data;
    int          req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_ni = 1'b1, sel_a_ni = 1'b1, sel_b_i = 1'b0, sel_c_ni = 1'b1;
  logic        adv_i = 1'b0, wr_ni = 1'b1, out_en_ni = 1'b1, interleave_i = 1'b0, sleep_i = 1'b0;
  logic [3:0]  byte_wr_ni = 4'hF;
  logic [5:0]  addr_i = '0;
  logic [35:0] dq_i = '0;
  logic [35:0] dq_o;
  logic        dq_oe_o;

  int          n_chk = 0, n_bad = 0;
  item_t       sb_q[$];
  item_t       last_it;
  logic [35:0] model [64];
  logic [35:0] bus_next = '0;
  bit          sleep_next = 1'b0;
  bit          m_asleep = 1'b0;
  int          m_op = 0;
  logic [5:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;
  bit          m_ilv = 1'b0;

  always #2.5 clk = ~clk;

  ftsram_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .sel_a_ni(sel_a_ni), .sel_b_i(sel_b_i),
    .sel_c_ni(sel_c_ni), .adv_i(adv_i), .wr_ni(wr_ni), .byte_wr_ni(byte_wr_ni), .out_en_ni(out_en_ni),
    .interleave_i(interleave_i), .sleep_i(sleep_i), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o)
  );

  function automatic logic [5:0] cur_addr();
    return {m_base[5:2], m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // driver: one command per clock, expectation for the cycle after its edge
  task automatic step(input bit ce_n, input bit sa_n, input bit sb, input bit sc_n, input bit adv,
                      input bit wr_n, input logic [3:0] bw_n, input logic [5:0] a, input bit ilv,
                      input logic [35:0] wd, input bit oe_n, input int req);
    item_t it;
    @(negedge clk); #1;
    dq_i = bus_next;
    sleep_i = sleep_next;
    clk_en_ni = ce_n; sel_a_ni = sa_n; sel_b_i = sb; sel_c_ni = sc_n; adv_i = adv;
    wr_ni = wr_n; byte_wr_ni = bw_n; addr_i = a; interleave_i = ilv; out_en_ni = oe_n;
    it.exp_oe = 1'b0; it.data = '0; it.req = req;
    if (m_asleep) begin
      m_op = 0;
    end else if (ce_n) begin
      it = last_it;
      it.req = req;
    end else begin
      if (!adv) begin
        if (sa_n || !sb || sc_n) m_op = 0;
        else begin
          m_op = wr_n ? 1 : 2; m_base = a; m_cnt = '0; m_ilv = ilv;
        end
      end else if (m_op != 0) m_cnt = m_cnt + 2'd1;
      if (m_op == 2) begin
        for (int l = 0; l < 4; l++) if (!bw_n[l]) model[cur_addr()][l*9 +: 9] = wd[l*9 +: 9];
        bus_next = wd;
      end else if (m_op == 1) begin
        it.exp_oe = !oe_n;
        it.data = model[cur_addr()];
      end
    end
    last_it = it;
    sb_q.push_back(it);
  endtask

  task automatic rd(input logic [5:0] a, input bit ilv, input int req);
    step(0, 0, 1, 0, 0, 1, 4'hF, a, ilv, '0, 0, req);
  endtask
  task automatic wr(input logic [5:0] a, input logic [3:0] bw, input logic [35:0] d, input int req);
    step(0, 0, 1, 0, 0, 0, bw, a, 0, d, 0, req);
  endtask
  task automatic cont(input logic [3:0] bw, input logic [35:0] d, input int req);
    step(0, 0, 1, 0, 1, 1, bw, '0, 0, d, 0, req);
  endtask
  task automatic stall(input int req);
    step(1, 0, 1, 0, 0, 1, 4'hF, '0, 0, '0, 0, req);
  endtask
  task automatic desel(input bit sa_n, input bit sb, input bit sc_n, input int req);
    step(0, sa_n, sb, sc_n, 0, 1, 4'hF, '0, 0, '0, 0, req);
  endtask

  // monitor: compare one expectation per clock, mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (dq_oe_o !== it.exp_oe) begin
          n_bad++;
          $display("FAIL R%0d: oe actual=%0b expected=%0b", it.req, dq_oe_o, it.exp_oe);
        end else if (it.exp_oe && dq_o !== it.data) begin
          n_bad++;
          $display("FAIL R%0d: data actual=%h expected=%h", it.req, dq_o, it.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    last_it.exp_oe = 1'b0; last_it.data = '0; last_it.req = 1;
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    n_chk++; // R1
    if (dq_oe_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: oe actual=%0b expected=0", dq_oe_o);
    end
    desel(1, 1, 0, 1);

    // clear the addresses used below
    for (int i = 0; i < 64; i++) wr(6'(i), 4'h0, '0, 5);

    // linear write burst from 0x0A: 0A,0B,08,09 (R6)
    wr(6'h0A, 4'h0, 36'h1_1111_1111, 6);
    cont(4'h0, 36'h2_2222_2222, 6);
    cont(4'h0, 36'h3_3333_3333, 6);
    cont(4'h0, 36'h4_4444_4444, 6);
    // interleaved read from 0x0B: 0B,0A,09,08 (R7)
    rd(6'h0B, 1, 7);
    cont(4'hF, '0, 7);
    cont(4'hF, '0, 7);
    cont(4'hF, '0, 7);
    // linear read from 0x09 with wrap (R6)
    rd(6'h09, 0, 6);
    cont(4'hF, '0, 6);
    cont(4'hF, '0, 6);
    cont(4'hF, '0, 6);
    cont(4'hF, '0, 6);

    // lane masking and forwarding (R5, R9)
    wr(6'h10, 4'h0, 36'hA_BCDE_F012, 5);
    wr(6'h10, 4'b1010, 36'h5_5555_5555, 5);
    rd(6'h10, 0, 9);
    wr(6'h20, 4'h0, 36'h0_0000_0F0F, 5);
    rd(6'h10, 0, 5);
    rd(6'h20, 0, 9);

    // alternating read/write on consecutive edges (R9)
    wr(6'h21, 4'h0, 36'h7_0000_0021, 9);
    rd(6'h21, 0, 9);
    wr(6'h22, 4'h0, 36'h7_0000_0022, 9);
    rd(6'h22, 0, 9);
    rd(6'h21, 0, 9);
    wr(6'h21, 4'b0111, 36'h8_8888_8888, 9);
    rd(6'h21, 0, 9);

    // per-beat strobes in a write burst (R8)
    wr(6'h30, 4'h0, 36'h0_1234_5678, 8);
    cont(4'b1110, 36'hF_FFFF_FFFF, 8);
    cont(4'b0111, 36'hE_EEEE_EEEE, 8);
    rd(6'h30, 0, 8);
    cont(4'hF, '0, 8);
    cont(4'hF, '0, 8);

    // stalls (R2)
    rd(6'h30, 0, 2);
    stall(2);
    stall(2);
    wr(6'h31, 4'h0, 36'h9_0000_0031, 2);
    stall(2);
    stall(2);
    rd(6'h31, 0, 2);

    // output enable gating (R4)
    step(0, 0, 1, 0, 0, 1, 4'hF, 6'h30, 0, '0, 1, 4);
    rd(6'h30, 0, 4);

    // deselect forms, each followed by a continue (R3)
    desel(1, 1, 0, 3);
    cont(4'hF, '0, 3);
    rd(6'h30, 0, 4);
    desel(0, 0, 0, 3);
    cont(4'hF, '0, 3);
    rd(6'h30, 0, 4);
    desel(0, 1, 1, 3);
    cont(4'hF, '0, 3);

    // sleep entry, ignored accesses, wake (R10, R11)
    sleep_next = 1'b1;
    desel(1, 1, 0, 10);
    desel(1, 1, 0, 10);
    m_asleep = 1'b1;
    wr(6'h30, 4'h0, 36'hD_EAD0_0000, 10);
    rd(6'h30, 0, 10);
    rd(6'h30, 0, 10);
    sleep_next = 1'b0;
    rd(6'h30, 0, 11);
    rd(6'h30, 0, 11);
    m_asleep = 1'b0;
    rd(6'h30, 0, 11);
    rd(6'h31, 0, 11);
    desel(1, 1, 0, 3);

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end

endmodule